// File: doc/BRIEF.md
# Arbiter Slot Schedule Builder

This block computes the time-slot schedule that a memory arbiter steps through. The schedule has 64 slots, and each slot names one of 14 requesters. The block keeps two independent sets of configuration, one for the external memory region and one for the internal memory region. Each set holds a reserved slot count and an active flag for every requester. Requesters are added through an admission port. The port turns a bandwidth figure into a slot count and rejects any request that would overbook the table.

A start pulse builds the schedule in two passes. In the first pass, requesters with reservations are taken in ascending index order and spread across the table at a fixed stride. The stride is the table size divided by the reservation. Whenever the target slot is already taken, placement slides forward one slot. In the second pass, the table is scanned from slot 0 upward. Each slot that is still free goes to the next active requester in a circular search. The finished table leaves the block as one write per cycle, slot 0 first. A done pulse follows the last write. The block does not issue memory grants.

Top module: `slot_table_builder`

## Requirements
- R1: After reset, busy, wr_en, done, adm_accept and adm_reject are all 0. Every reservation count and active flag in both regions reads as zero, so a build made straight after reset behaves as if no requester is active.
- R2: When start is 1 while the block is idle, a build of the region on build_region begins, and busy reads 1 from the next cycle. At the start of every build, all 64 slots are marked free. The free marker is the value 15, which is the client count plus one.
- R3: First pass. Requesters are taken in ascending index order, and a requester with a zero count is skipped. For a count R, the stride is 64/R using integer division. The position starts at 0. If the slot at the position is occupied, the position moves up by 1. Otherwise the slot takes the requester and the position moves up by the stride. The pass for that requester ends once the position reaches 64.
- R4: Second pass. Slots are scanned from 0 to 63 with a pointer that starts at requester 0. Each free slot takes the first active requester found by a circular search that begins at the pointer. The pointer then moves to one past that requester, wrapping from 13 to 0.
- R5: When the circular search finds no active requester, the free slot takes the pointer's own index. In a region with no reservations and no active requesters, slot s therefore holds s mod 14.
- R6: The table is written out as 64 writes on consecutive cycles. The slot index rises from 0 to 63. wr_region equals the region being built, and wr_client (4 bits) is always below 14.
- R7: done is 1 for exactly one cycle, in the cycle right after the last write. busy reads 0 from that same cycle.
- R8: A start pulse that arrives while busy is 1 has no effect. The build in progress keeps its region and still makes exactly 64 writes.
- R9: The slot request for a bandwidth B is 64 / (MAX / B), using integer division. MAX is 100,000,000 for region 0 (external) and 400,000,000 for region 1 (internal). A B above MAX requests 64 slots.
- R10: A request is rejected when the sum of the region's reserved counts, plus the number of its active requesters, plus the new request, plus 1, exceeds 64. If the request is accepted, the requester is marked active and its count is replaced by the new request. adm_accept or adm_reject is 1 for one cycle, in the cycle after adm_valid.
- R11: A request is also rejected when B is 0 or the requester index is 14 or more. A rejected request leaves every count and flag unchanged.
- R12: While busy is 1, adm_valid is ignored. Neither result pulse is raised and no count or flag changes.
- R13: The two regions keep separate counts, flags and schedules. Admitting requests in one region does not change the table built for the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a schedule build (taken only when idle) |
| build_region | input | 1 | Region to build: 0 external, 1 internal |
| adm_valid | input | 1 | Admission request strobe |
| adm_region | input | 1 | Region of the admission request |
| adm_client | input | 4 | Requester index of the admission request |
| adm_bw | input | 32 | Requested bandwidth |
| adm_accept | output | 1 | Request accepted (one-cycle pulse) |
| adm_reject | output | 1 | Request rejected (one-cycle pulse) |
| busy | output | 1 | Build in progress |
| wr_en | output | 1 | Slot write strobe |
| wr_region | output | 1 | Region of the slot write |
| wr_slot | output | 6 | Slot index of the write |
| wr_client | output | 4 | Requester written into the slot |
| done | output | 1 | Build finished (one-cycle pulse) |

## Verification
The assertions check the following on every cycle:
- The write stream is well formed: the first slot is 0, slot indices rise by one, no free marker ever leaves the block, and the region is held for the whole build.
- done appears only right after slot 63 and lasts a single cycle.
- Admission never raises both result pulses, never answers while busy, and leaves the stored configuration untouched on a reject.

The bench's scenarios are the only place where the actual slot contents are checked. The bench compares them against an arithmetic model of both passes. Those scenarios also cover:
- the bandwidth-to-slot conversion;
- the overbooking limit;
- the effect of a start or request injected in the middle of a build;
- independence between the two regions.

// File: rtl/stb_pkg.sv
package stb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PLACE = 2'd1,
        ST_FILL  = 2'd2,
        ST_END   = 2'd3
    } bld_st_e;

    localparam int unsigned REGIONS = 2;

endpackage

// File: rtl/stb_bw_to_slots.sv
module stb_bw_to_slots #(
    parameter int          N_SLOTS    = 64,
    parameter int          BW_W       = 32,
    parameter int unsigned EXT_MAX_BW = 100_000_000,
    parameter int unsigned INT_MAX_BW = 400_000_000,
    localparam int         CNT_W      = $clog2(N_SLOTS + 1)
) (
    input  logic [BW_W-1:0]  bw,
    input  logic             region,
    output logic [CNT_W-1:0] slots,
    output logic             bw_ok
);
    logic [BW_W-1:0] bw_max;
    logic [BW_W-1:0] ratio;

    always_comb begin
        bw_max = region ? BW_W'(INT_MAX_BW) : BW_W'(EXT_MAX_BW);
        bw_ok  = (bw != '0);
        ratio  = bw_ok ? (bw_max / bw) : '0;
        if (ratio == '0) begin
            slots = CNT_W'(N_SLOTS);
        end else if (ratio > BW_W'(N_SLOTS)) begin
            slots = '0;
        end else begin
            slots = CNT_W'(BW_W'(N_SLOTS) / ratio);
        end
    end

    // R9: a computed request never exceeds the table size
    always_comb begin
        a_r9_slots_bound: assert (slots <= CNT_W'(N_SLOTS));
    end

endmodule

// File: rtl/stb_rr_pick.sv
module stb_rr_pick #(
    parameter int N_CLIENTS = 14,
    localparam int ID_W     = $clog2(N_CLIENTS + 2)
) (
    input  logic [N_CLIENTS-1:0] act,
    input  logic [ID_W-1:0]      ptr,
    output logic [ID_W-1:0]      pick,
    output logic [ID_W-1:0]      ptr_nx
);
    always_comb begin
        pick = ptr;
        for (int i = N_CLIENTS - 1; i >= 0; i--) begin
            int idx;
            idx = int'(ptr) + i;
            if (idx >= N_CLIENTS) begin
                idx = idx - N_CLIENTS;
            end
            if (act[idx]) begin
                pick = ID_W'(idx);
            end
        end
        ptr_nx = (pick == ID_W'(N_CLIENTS - 1)) ? '0 : pick + 1'b1;
    end

    // R4/R5: the chosen requester is active unless none is active
    always_comb begin
        a_r4_pick_active: assert ((act == '0) || act[pick]);
    end

endmodule

// File: rtl/stb_region_store.sv
module stb_region_store #(
    parameter int  N_SLOTS   = 64,
    parameter int  N_CLIENTS = 14,
    localparam int CNT_W     = $clog2(N_SLOTS + 1),
    localparam int ID_W      = $clog2(N_CLIENTS + 2),
    localparam int SUM_W     = CNT_W + $clog2(N_CLIENTS + 1) + 1
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             en,
    input  logic                             adm_valid,
    input  logic                             adm_region,
    input  logic [ID_W-1:0]                  adm_client,
    input  logic [CNT_W-1:0]                 adm_slots,
    input  logic                             adm_bw_ok,
    input  logic                             rd_region,
    output logic [N_CLIENTS-1:0][CNT_W-1:0]  rd_cnt,
    output logic [N_CLIENTS-1:0]             rd_act,
    output logic                             accept,
    output logic                             reject
);
    import stb_pkg::*;

    typedef struct packed {
        logic [REGIONS-1:0][N_CLIENTS-1:0][CNT_W-1:0] cnt;
        logic [REGIONS-1:0][N_CLIENTS-1:0]            act;
        logic                                         acc;
        logic                                         rej;
    } store_t;

    store_t           q, d;
    logic [SUM_W-1:0] sum_cnt;
    logic [SUM_W-1:0] sum_act;
    logic [SUM_W-1:0] need;
    logic             cli_ok;

    always_comb begin
        sum_cnt = '0;
        sum_act = '0;
        for (int i = 0; i < N_CLIENTS; i++) begin
            sum_cnt = sum_cnt + SUM_W'(q.cnt[adm_region][i]);
            sum_act = sum_act + SUM_W'(q.act[adm_region][i]);
        end
        need   = sum_cnt + sum_act + SUM_W'(adm_slots) + SUM_W'(1);
        cli_ok = (adm_client < ID_W'(N_CLIENTS));
    end

    always_comb begin
        d     = q;
        d.acc = 1'b0;
        d.rej = 1'b0;
        if (en && adm_valid) begin
            if (adm_bw_ok && cli_ok && (need <= SUM_W'(N_SLOTS))) begin
                d.acc                            = 1'b1;
                d.act[adm_region][adm_client]    = 1'b1;
                d.cnt[adm_region][adm_client]    = adm_slots;
            end else begin
                d.rej = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign rd_cnt = q.cnt[rd_region];
    assign rd_act = q.act[rd_region];
    assign accept = q.acc;
    assign reject = q.rej;

    a_r10_one_result: assert property (@(posedge clk) disable iff (!rst_n)
        !(accept && reject));

    a_r12_idle_only: assert property (@(posedge clk) disable iff (!rst_n)
        (accept || reject) |-> $past(en && adm_valid));

    a_r11_reject_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        reject |-> ((q.cnt == $past(q.cnt)) && (q.act == $past(q.act))));

    a_r12_busy_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!en) |-> ((q.cnt == $past(q.cnt)) && (q.act == $past(q.act))));

endmodule

// File: rtl/slot_table_builder.sv
module slot_table_builder #(
    parameter int          N_SLOTS    = 64,
    parameter int          N_CLIENTS  = 14,
    parameter int          BW_W       = 32,
    parameter int unsigned EXT_MAX_BW = 100_000_000,
    parameter int unsigned INT_MAX_BW = 400_000_000,
    localparam int         SLOT_W     = $clog2(N_SLOTS),
    localparam int         CNT_W      = $clog2(N_SLOTS + 1),
    localparam int         POS_W      = CNT_W + 1,
    localparam int         ID_W       = $clog2(N_CLIENTS + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              build_region,
    input  logic              adm_valid,
    input  logic              adm_region,
    input  logic [ID_W-1:0]   adm_client,
    input  logic [BW_W-1:0]   adm_bw,
    output logic              adm_accept,
    output logic              adm_reject,
    output logic              busy,
    output logic              wr_en,
    output logic              wr_region,
    output logic [SLOT_W-1:0] wr_slot,
    output logic [ID_W-1:0]   wr_client,
    output logic              done
);
    import stb_pkg::*;

    localparam logic [ID_W-1:0] FREE_MARK = ID_W'(N_CLIENTS + 1);

    typedef struct packed {
        bld_st_e                           st;
        logic                              reg_sel;
        logic [ID_W-1:0]                   cl;
        logic [POS_W-1:0]                  pos;
        logic [SLOT_W-1:0]                 slot;
        logic [ID_W-1:0]                   ptr;
        logic [N_SLOTS-1:0][ID_W-1:0]      tab;
        logic                              wr_en;
        logic [SLOT_W-1:0]                 wr_slot;
        logic [ID_W-1:0]                   wr_cl;
        logic                              done;
    } bld_t;

    bld_t                             q, d;
    logic [CNT_W-1:0]                 adm_slots;
    logic                             adm_bw_ok;
    logic [N_CLIENTS-1:0][CNT_W-1:0]  rd_cnt;
    logic [N_CLIENTS-1:0]             rd_act;
    logic [CNT_W-1:0]                 cur_cnt;
    logic [CNT_W-1:0]                 stride;
    logic [ID_W-1:0]                  pick;
    logic [ID_W-1:0]                  ptr_nx;
    logic                             idle;

    assign idle = (q.st == ST_IDLE);

    stb_bw_to_slots #(
        .N_SLOTS   (N_SLOTS),
        .BW_W      (BW_W),
        .EXT_MAX_BW(EXT_MAX_BW),
        .INT_MAX_BW(INT_MAX_BW)
    ) conv_i (
        .bw    (adm_bw),
        .region(adm_region),
        .slots (adm_slots),
        .bw_ok (adm_bw_ok)
    );

    stb_region_store #(
        .N_SLOTS  (N_SLOTS),
        .N_CLIENTS(N_CLIENTS)
    ) store_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (idle),
        .adm_valid (adm_valid),
        .adm_region(adm_region),
        .adm_client(adm_client),
        .adm_slots (adm_slots),
        .adm_bw_ok (adm_bw_ok),
        .rd_region (q.reg_sel),
        .rd_cnt    (rd_cnt),
        .rd_act    (rd_act),
        .accept    (adm_accept),
        .reject    (adm_reject)
    );

    stb_rr_pick #(
        .N_CLIENTS(N_CLIENTS)
    ) pick_i (
        .act   (rd_act),
        .ptr   (q.ptr),
        .pick  (pick),
        .ptr_nx(ptr_nx)
    );

    always_comb begin
        cur_cnt = rd_cnt[q.cl];
        stride  = (cur_cnt == '0) ? '0 : CNT_W'(32'(N_SLOTS) / 32'(cur_cnt));
    end

    always_comb begin
        d       = q;
        d.wr_en = 1'b0;
        d.done  = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.st      = ST_PLACE;
                    d.reg_sel = build_region;
                    d.cl      = '0;
                    d.pos     = '0;
                    for (int s = 0; s < N_SLOTS; s++) begin
                        d.tab[s] = FREE_MARK;
                    end
                end
            end
            ST_PLACE: begin
                if ((cur_cnt == '0) || (q.pos >= POS_W'(N_SLOTS))) begin
                    d.pos = '0;
                    if (q.cl == ID_W'(N_CLIENTS - 1)) begin
                        d.st   = ST_FILL;
                        d.slot = '0;
                        d.ptr  = '0;
                    end else begin
                        d.cl = q.cl + 1'b1;
                    end
                end else if (q.tab[q.pos[SLOT_W-1:0]] != FREE_MARK) begin
                    d.pos = q.pos + 1'b1;
                end else begin
                    d.tab[q.pos[SLOT_W-1:0]] = q.cl;
                    d.pos = q.pos + POS_W'(stride);
                end
            end
            ST_FILL: begin
                d.wr_en   = 1'b1;
                d.wr_slot = q.slot;
                if (q.tab[q.slot] == FREE_MARK) begin
                    d.wr_cl = pick;
                    d.ptr   = ptr_nx;
                end else begin
                    d.wr_cl = q.tab[q.slot];
                end
                if (q.slot == SLOT_W'(N_SLOTS - 1)) begin
                    d.st = ST_END;
                end else begin
                    d.slot = q.slot + 1'b1;
                end
            end
            ST_END: begin
                d.done = 1'b1;
                d.st   = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy      = !idle;
    assign wr_en     = q.wr_en;
    assign wr_region = q.reg_sel;
    assign wr_slot   = q.wr_slot;
    assign wr_client = q.wr_cl;
    assign done      = q.done;

    a_r6_first_slot: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_en) |-> (wr_slot == '0));

    a_r6_slot_step: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(wr_en)) |-> (wr_slot == $past(wr_slot) + 1'b1));

    a_r6_no_free_mark: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_client < ID_W'(N_CLIENTS)));

    a_r7_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(wr_en) && ($past(wr_slot) == SLOT_W'(N_SLOTS - 1)) && !busy));

    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r8_region_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(wr_region));

endmodule

// File: tb/slot_table_builder_tb_top.sv
module slot_table_builder_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        build_region = 1'b0;
    logic        adm_valid = 1'b0;
    logic        adm_region = 1'b0;
    logic [3:0]  adm_client = '0;
    logic [31:0] adm_bw = '0;
    logic        adm_accept, adm_reject, busy, wr_en, wr_region, done;
    logic [5:0]  wr_slot;
    logic [3:0]  wr_client;

    int n_chk = 0;
    int n_err = 0;
    int          m_cnt [2][14];
    bit          m_act [2][14];
    int          exp_tab [64];

    always #5 clk = ~clk;

    slot_table_builder dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .build_region(build_region),
        .adm_valid(adm_valid), .adm_region(adm_region), .adm_client(adm_client),
        .adm_bw(adm_bw), .adm_accept(adm_accept), .adm_reject(adm_reject),
        .busy(busy), .wr_en(wr_en), .wr_region(wr_region), .wr_slot(wr_slot),
        .wr_client(wr_client), .done(done)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int r = 0; r < 2; r++)
            for (int c = 0; c < 14; c++) begin
                m_cnt[r][c] = 0;
                m_act[r][c] = 1'b0;
            end
        @(negedge clk);
    endtask

    function automatic void compute_exp(input int rg);
        int p, iv, ptr, first;
        for (int s = 0; s < 64; s++) exp_tab[s] = 15;
        for (int c = 0; c < 14; c++) begin
            if (m_cnt[rg][c] != 0) begin
                iv = 64 / m_cnt[rg][c];
                p  = 0;
                while (p < 64) begin
                    if (exp_tab[p] != 15) p++;
                    else begin
                        exp_tab[p] = c;
                        p += iv;
                    end
                end
            end
        end
        ptr = 0;
        for (int s = 0; s < 64; s++) begin
            if (exp_tab[s] == 15) begin
                first = ptr;
                while (!m_act[rg][ptr]) begin
                    ptr = (ptr + 1) % 14;
                    if (ptr == first) break;
                end
                exp_tab[s] = ptr;
                ptr = (ptr + 1) % 14;
            end
        end
    endfunction

    task automatic admit(input int rg, input int cl, input int unsigned bw, input string tag);
        int unsigned mx, ratio;
        int  slots, sum;
        bit  ok;
        mx    = (rg != 0) ? 400_000_000 : 100_000_000;
        ok    = (bw != 0) && (cl < 14);
        ratio = (bw != 0) ? mx / bw : 0;
        slots = (ratio == 0) ? 64 : int'(64 / ratio);
        sum   = 0;
        for (int c = 0; c < 14; c++) sum += m_cnt[rg][c] + int'(m_act[rg][c]);
        if (sum + slots + 1 > 64) ok = 1'b0;
        @(negedge clk);
        adm_valid = 1'b1; adm_region = rg[0]; adm_client = cl[3:0]; adm_bw = bw;
        @(negedge clk);
        adm_valid = 1'b0;
        chk(adm_accept == ok, {tag, " accept"}, adm_accept, ok);
        chk(adm_reject == !ok, {tag, " reject"}, adm_reject, !ok);
        @(negedge clk);
        chk(!adm_accept && !adm_reject, "R10 result pulse width", adm_accept | adm_reject, 0);
        if (ok) begin
            m_act[rg][cl] = 1'b1;
            m_cnt[rg][cl] = slots;
        end
    endtask

    task automatic build(input int rg, input bit inject, input string tag);
        int  n, last, cyc;
        bit  fin;
        compute_exp(rg);
        @(negedge clk);
        start = 1'b1; build_region = rg[0];
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R2 busy after start", busy, 1);
        n = 0; last = -10; cyc = 0; fin = 1'b0;
        while (!fin && cyc < 4000) begin
            if (wr_en) begin
                chk(wr_slot == n[5:0], "R6 slot order", wr_slot, n);
                chk(wr_region == rg[0], "R8 write region", wr_region, rg);
                if (n < 64)
                    chk(wr_client == exp_tab[n][3:0], tag, wr_client, exp_tab[n]);
                n++;
                last = cyc;
            end
            if (done) begin
                chk(n == 64, "R6 write count", n, 64);
                chk(cyc == last + 1, "R7 done timing", cyc, last + 1);
                chk(busy == 1'b0, "R7 busy low at done", busy, 0);
                fin = 1'b1;
            end
            if (inject && cyc == 3) begin
                chk(!adm_accept && !adm_reject, "R12 request while busy",
                    adm_accept | adm_reject, 0);
                start = 1'b0; adm_valid = 1'b0;
            end
            if (inject && cyc == 2) begin
                start = 1'b1; build_region = !rg[0];
                adm_valid = 1'b1; adm_region = rg[0]; adm_client = 4'd6; adm_bw = 1_000_000;
            end
            if (!fin) begin
                @(negedge clk);
                cyc++;
            end
        end
        chk(fin, "R7 build finished", fin, 1);
        @(negedge clk);
        chk(done == 1'b0, "R7 done one cycle", done, 0);
        chk(busy == 1'b0 && wr_en == 1'b0, "R8 no second build", busy | wr_en, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_err++;
        $display("FAIL R7 watchdog: actual 0 expected 1");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        do_reset();
        chk(!busy && !wr_en && !done && !adm_accept && !adm_reject,
            "R1 reset outputs", {busy, wr_en, done, adm_accept, adm_reject}, 0);
        // R1, R5: empty region fills slot s with s mod 14
        build(0, 1'b0, "R5 empty fill");
        build(1, 1'b0, "R1 empty region1");

        // R9, R10, R11: admission in region 0
        admit(0, 10, 25_000_000, "R9 ext 16 slots");
        admit(0, 11, 12_500_000, "R9 ext 8 slots");
        admit(0, 2, 50_000_000, "R10 ext 32 slots");
        admit(0, 5, 10_000_000, "R10 overbook");
        admit(0, 5, 1_000_000, "R10 zero slots");
        admit(0, 4, 0, "R11 zero bandwidth");
        admit(0, 14, 5_000_000, "R11 bad client");
        admit(0, 3, 200_000_000, "R9 above max");
        // R3, R4, R8, R12: build with injected start and request
        build(0, 1'b1, "R3 R4 region0 table");

        // R13: region 1 configured independently
        admit(1, 0, 400_000_000, "R10 full table");
        admit(1, 7, 100_000_000, "R9 int 16 slots");
        admit(1, 13, 50_000_000, "R9 int 8 slots");
        admit(1, 3, 30_000_000, "R9 int 4 slots");
        build(1, 1'b0, "R13 region1 table");
        build(0, 1'b0, "R13 region0 unchanged");

        // R3, R4, R9: sweep of reservation sizes in both regions
        for (int k = 1; k <= 65; k++) begin
            int rg;
            int unsigned mx;
            do_reset();
            rg = k % 2;
            mx = (rg != 0) ? 400_000_000 : 100_000_000;
            admit(rg, k % 14, mx / k, "R9 sweep request");
            admit(rg, (k * 3 + 1) % 14, 1, "R10 sweep active");
            build(rg, 1'b0, "R3 sweep table");
        end

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule